// File: doc/BRIEF.md
# Dual-Channel High/Low Count PWM Generator

This block drives two PWM outputs. Rather than a period plus a compare value, each channel is programmed with two separate 16-bit counts. One count sets how many counting ticks the output stays high, and the other sets how many it stays low. The channel alternates between the two phases. Each channel has its own prescaler, which picks one of four external clock-enable strobes and divides it by a programmable amount to produce its counting tick.

Software reaches the block through a single-cycle register port. Writes take effect on the clock edge, and reads are combinational from the address. The port holds one count register per channel and a shared control word. The control word holds, for each channel, the enable, the strobe select, the divider, an invert flag and a constant-output flag. In constant mode, 0% and 100% duty are held with no switching edges. The invert flag also sets the idle level of a disabled channel.

Top module: `pwm_pair`

## Requirements
- R1: Synchronous active-high reset clears all three registers, so every readback is zero and both outputs are low.
- R2: Register address 0 holds channel A's counts and address 1 holds channel B's. In each, the low count is bits 15:0 and the high count is bits 31:16. Address 2 holds the control word. Each register reads back exactly the 32-bit value last written. Address 3 always reads zero, and writes to it change nothing.
- R3: Control bit 0 enables channel A and bit 1 enables channel B. In the first cycle that the enable reads set, the output is still low. From the next clock edge the channel starts a high phase. It then alternates: high for the high count of ticks, then low for the low count of ticks.
- R4: Bits 5:4 (A) and 7:6 (B) select which of the four strobes `src_stb` feeds the prescaler. Bits 14:8 (A) and 22:16 (B) hold a divider value d, and one counting tick is produced for every d+1 selected strobes. The prescaler is cleared while its channel is disabled.
- R5: New counts written while a channel runs are taken only when the next high phase starts. The phase in progress, and the low phase that follows it, keep the counts that were latched at that high phase's start.
- R6: A phase whose count is zero is skipped when it would start. If both counts are zero, the raw output stays low, and the counts are rechecked on every tick.
- R7: Control bits 28 (A) and 29 (B) select constant mode. In this mode an enabled channel's raw level is high when the high count is nonzero and the low count is zero, and low otherwise. The level shows no edges while the registers are unchanged.
- R8: Control bits 26 (A) and 27 (B) invert the channel's output. A disabled channel drives the invert bit's value: high when the bit is set, low when it is clear.
- R9: The two channels run independently, each from its own fields, prescaler and phase counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from `bus_addr` |
| src_stb | input | 4 | Four selectable clock-enable strobes |
| pwm_out | output | 2 | PWM outputs, bit 0 is channel A and bit 1 is channel B |

## Verification
The bench rewrites the counts in the middle of a phase. A design that reloads the counts right away would shorten or stretch the running phase, and the per-cycle model catches the difference. It programs zero counts, one at a time and both together. A channel that failed to skip an empty phase would show a spurious high or low cycle, and one that handled both zero wrongly would toggle or hang high. It also runs divided and alternate strobe sources, and constant mode with and without invert. A wrong divider shows up as twice the expected edge rate. A constant mode that still counted would emit edges. An invert that was gated by the enable would leave a disabled channel low when it should be high.

// File: rtl/pwm_pair_pkg.sv
package pwm_pair_pkg;
    localparam int NCH        = 2;
    localparam int CNT_W      = 16;
    localparam int DIV_W      = 7;
    localparam int SEL_W      = 2;
    localparam int NSRC       = 1 << SEL_W;
    localparam int REG_W      = 32;
    localparam int ADDR_W     = 2;
    localparam int EN_LSB     = 0;
    localparam int SEL_LSB    = 4;
    localparam int DIV_LSB    = 8;
    localparam int DIV_STRIDE = 8;
    localparam int INV_LSB    = 26;
    localparam int KONST_LSB  = 28;
    localparam logic [ADDR_W-1:0] ADDR_CTRL = ADDR_W'(NCH);

    typedef enum logic [1:0] {PH_OFF, PH_HIGH, PH_LOW, PH_ZERO} phase_e;

    typedef struct packed {
        logic             en;
        logic [SEL_W-1:0] sel;
        logic [DIV_W-1:0] div;
        logic             inv;
        logic             konst;
    } chan_cfg_t;

    // high count occupies the upper half, as in the register layout
    typedef struct packed {
        logic [CNT_W-1:0] hi;
        logic [CNT_W-1:0] lo;
    } counts_t;

    typedef struct packed {
        phase_e           ph;
        logic [CNT_W-1:0] left;
        logic [CNT_W-1:0] lo_l;
    } phase_st_t;

    function automatic chan_cfg_t cfg_of(logic [REG_W-1:0] c, int ch);
        chan_cfg_t r;
        r.en    = c[EN_LSB + ch];
        r.sel   = c[SEL_LSB + SEL_W*ch +: SEL_W];
        r.div   = c[DIV_LSB + DIV_STRIDE*ch +: DIV_W];
        r.inv   = c[INV_LSB + ch];
        r.konst = c[KONST_LSB + ch];
        return r;
    endfunction

    // state at the start of a high phase; empty phases are skipped
    function automatic phase_st_t begin_high(counts_t c);
        phase_st_t s;
        s.lo_l = c.lo;
        if (c.hi != '0) begin
            s.ph   = PH_HIGH;
            s.left = c.hi;
        end else if (c.lo != '0) begin
            s.ph   = PH_LOW;
            s.left = c.lo;
        end else begin
            s.ph   = PH_ZERO;
            s.left = '0;
        end
        return s;
    endfunction
endpackage

// File: rtl/pwm_regfile.sv
module pwm_regfile
    import pwm_pair_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        we,
    input  logic [ADDR_W-1:0]           addr,
    input  logic [REG_W-1:0]            wdata,
    output logic [REG_W-1:0]            rdata,
    output logic [REG_W-1:0]            ctrl_q,
    output logic [NCH-1:0][REG_W-1:0]   cnt_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            cnt_q  <= '0;
        end else if (we) begin
            if (addr == ADDR_CTRL)
                ctrl_q <= wdata;
            for (int i = 0; i < NCH; i++)
                if (addr == ADDR_W'(i))
                    cnt_q[i] <= wdata;
        end
    end

    always_comb begin
        rdata = '0;
        if (addr == ADDR_CTRL)
            rdata = ctrl_q;
        for (int i = 0; i < NCH; i++)
            if (addr == ADDR_W'(i))
                rdata = cnt_q[i];
    end
endmodule

// File: rtl/pwm_prescale.sv
module pwm_prescale
    import pwm_pair_pkg::*;
#(
    parameter int P_NSRC  = NSRC,
    parameter int P_SEL_W = SEL_W,
    parameter int P_DIV_W = DIV_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               en,
    input  logic [P_SEL_W-1:0] sel,
    input  logic [P_DIV_W-1:0] div,
    input  logic [P_NSRC-1:0]  src_stb,
    output logic               tick
);
    logic [P_DIV_W-1:0] pc_q;
    logic               stb;

    assign stb  = src_stb[sel];
    // >= keeps the counter bounded when the divider shrinks mid-count
    assign tick = en && stb && (pc_q >= div);

    always_ff @(posedge clk) begin
        if (rst || !en)
            pc_q <= '0;
        else if (stb)
            pc_q <= tick ? '0 : pc_q + P_DIV_W'(1);
    end
endmodule

// File: rtl/pwm_phase.sv
module pwm_phase
    import pwm_pair_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  chan_cfg_t cfg,
    input  counts_t   cnt,
    input  logic      tick,
    output logic      level
);
    phase_st_t st_q, st_d;
    logic      raw;

    always_comb begin
        st_d = st_q;
        if (!cfg.en) begin
            st_d.ph   = PH_OFF;
            st_d.left = '0;
            st_d.lo_l = '0;
        end else if (st_q.ph == PH_OFF) begin
            st_d = begin_high(cnt);
        end else if (tick) begin
            unique case (st_q.ph)
                PH_HIGH: begin
                    if (st_q.left > CNT_W'(1))
                        st_d.left = st_q.left - CNT_W'(1);
                    else if (st_q.lo_l != '0) begin
                        st_d.ph   = PH_LOW;
                        st_d.left = st_q.lo_l;
                    end else
                        st_d = begin_high(cnt);
                end
                PH_LOW: begin
                    if (st_q.left > CNT_W'(1))
                        st_d.left = st_q.left - CNT_W'(1);
                    else
                        st_d = begin_high(cnt);
                end
                default: st_d = begin_high(cnt);
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.ph   <= PH_OFF;
            st_q.left <= '0;
            st_q.lo_l <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        if (cfg.konst)
            raw = (cnt.hi != '0) && (cnt.lo == '0);
        else
            raw = (st_q.ph == PH_HIGH);
        level = cfg.en ? (raw ^ cfg.inv) : cfg.inv;
    end
endmodule

// File: rtl/pwm_pair.sv
module pwm_pair
    import pwm_pair_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    input  logic [NSRC-1:0]   src_stb,
    output logic [NCH-1:0]    pwm_out
);
    logic [REG_W-1:0]          ctrl_q;
    logic [NCH-1:0][REG_W-1:0] cnt_q;

    pwm_regfile u_regs (
        .clk    (clk),
        .rst    (rst),
        .we     (bus_we),
        .addr   (bus_addr),
        .wdata  (bus_wdata),
        .rdata  (bus_rdata),
        .ctrl_q (ctrl_q),
        .cnt_q  (cnt_q)
    );

    for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
        chan_cfg_t cfg;
        counts_t   cnt;
        logic      tick;

        assign cfg = cfg_of(ctrl_q, ch);
        assign cnt = counts_t'(cnt_q[ch]);

        pwm_prescale u_pre (
            .clk     (clk),
            .rst     (rst),
            .en      (cfg.en),
            .sel     (cfg.sel),
            .div     (cfg.div),
            .src_stb (src_stb),
            .tick    (tick)
        );

        pwm_phase u_phase (
            .clk   (clk),
            .rst   (rst),
            .cfg   (cfg),
            .cnt   (cnt),
            .tick  (tick),
            .level (pwm_out[ch])
        );
    end
endmodule

// File: rtl/pwm_pair_chk.sv
module pwm_pair_chk
    import pwm_pair_pkg::*;
(
    input logic                      clk,
    input logic                      rst,
    input logic                      bus_we,
    input logic [ADDR_W-1:0]         bus_addr,
    input logic [REG_W-1:0]          bus_wdata,
    input logic [REG_W-1:0]          ctrl_q,
    input logic [NCH-1:0][REG_W-1:0] cnt_q,
    input logic [NCH-1:0]            pwm_out
);
    p_reset_low_r1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (pwm_out == '0));

    p_ctrl_write_r2: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == ADDR_CTRL) |=> (ctrl_q == $past(bus_wdata)));

    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        p_cnt_write_r2: assert property (@(posedge clk) disable iff (rst)
            (bus_we && bus_addr == ADDR_W'(ch)) |=> (cnt_q[ch] == $past(bus_wdata)));

        p_const_steady_r7: assert property (@(posedge clk) disable iff (rst)
            (ctrl_q[EN_LSB+ch] && ctrl_q[KONST_LSB+ch] &&
             $past(ctrl_q[EN_LSB+ch] && ctrl_q[KONST_LSB+ch]) &&
             $stable(ctrl_q[INV_LSB+ch]) && $stable(cnt_q[ch]))
            |-> $stable(pwm_out[ch]));

        p_off_steady_r8: assert property (@(posedge clk) disable iff (rst)
            (!ctrl_q[EN_LSB+ch] && $past(!ctrl_q[EN_LSB+ch]) &&
             $stable(ctrl_q[INV_LSB+ch]))
            |-> $stable(pwm_out[ch]));
    end
endmodule

bind pwm_pair pwm_pair_chk i_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .ctrl_q    (ctrl_q),
    .cnt_q     (cnt_q),
    .pwm_out   (pwm_out)
);

// File: tb/test_pwm_pair.sv
`timescale 1ns/1ps
module test_pwm_pair;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_we = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [3:0]  src_stb = '0;
    logic [1:0]  pwm_out;

    int    n_tests = 0;
    int    n_fail  = 0;
    bit    cmp_on  = 0;
    bit    done    = 0;
    string cur_req = "R1";

    always #2.5 clk = ~clk;

    pwm_pair i_pwm_pair (
        .clk       (clk),
        .rst       (rst),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .src_stb   (src_stb),
        .pwm_out   (pwm_out)
    );

    // strobe sources: always, every 2nd, every 3rd, pseudo-random
    int         cyc = 0;
    logic [7:0] lfsr = 8'h5a;
    always @(negedge clk) begin
        cyc  <= cyc + 1;
        lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        src_stb <= {lfsr[0], (cyc % 3) == 0, (cyc % 2) == 0, 1'b1};
    end

    // behavioural reference model
    logic [31:0] m_ctrl;
    logic [31:0] m_cnt [2];
    int m_ph [2];   // 0 off, 1 high, 2 low, 3 both-zero
    int m_left [2];
    int m_lol [2];
    int m_pc [2];

    task automatic fresh(int ch, int hi, int lo);
        m_lol[ch] = lo;
        if (hi > 0) begin m_ph[ch] = 1; m_left[ch] = hi; end
        else if (lo > 0) begin m_ph[ch] = 2; m_left[ch] = lo; end
        else begin m_ph[ch] = 3; m_left[ch] = 0; end
    endtask

    always @(posedge clk) begin
        if (rst) begin
            m_ctrl = '0;
            for (int c = 0; c < 2; c++) begin
                m_cnt[c] = '0; m_ph[c] = 0; m_left[c] = 0; m_lol[c] = 0; m_pc[c] = 0;
            end
        end else begin
            for (int c = 0; c < 2; c++) begin
                bit en, tk;
                int sel, dv, hi, lo;
                en  = m_ctrl[c];
                sel = int'((m_ctrl >> (4 + 2*c)) & 32'h3);
                dv  = int'((m_ctrl >> (8 + 8*c)) & 32'h7f);
                hi  = int'(m_cnt[c] >> 16);
                lo  = int'(m_cnt[c] & 32'hffff);
                tk  = 0;
                if (!en) m_pc[c] = 0;
                else if (src_stb[sel]) begin
                    if (m_pc[c] >= dv) begin m_pc[c] = 0; tk = 1; end
                    else m_pc[c] = m_pc[c] + 1;
                end
                if (!en) begin m_ph[c] = 0; m_left[c] = 0; m_lol[c] = 0; end
                else if (m_ph[c] == 0) fresh(c, hi, lo);
                else if (tk) begin
                    if (m_ph[c] == 1) begin
                        if (m_left[c] > 1) m_left[c]--;
                        else if (m_lol[c] > 0) begin m_ph[c] = 2; m_left[c] = m_lol[c]; end
                        else fresh(c, hi, lo);
                    end else if (m_ph[c] == 2) begin
                        if (m_left[c] > 1) m_left[c]--;
                        else fresh(c, hi, lo);
                    end else fresh(c, hi, lo);
                end
            end
            if (bus_we) begin
                if (bus_addr == 2'd2) m_ctrl = bus_wdata;
                else if (bus_addr < 2'd2) m_cnt[bus_addr[0]] = bus_wdata;
            end
        end
    end

    function automatic bit model_out(int c);
        bit en, inv, kon, raw;
        int hi, lo;
        en  = m_ctrl[c];
        inv = m_ctrl[26 + c];
        kon = m_ctrl[28 + c];
        hi  = int'(m_cnt[c] >> 16);
        lo  = int'(m_cnt[c] & 32'hffff);
        raw = kon ? (hi != 0 && lo == 0) : (m_ph[c] == 1);
        return en ? (raw ^ inv) : inv;
    endfunction

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (cmp_on && !done) begin
            for (int c = 0; c < 2; c++) begin
                n_tests++;
                if (pwm_out[c] !== model_out(c)) begin
                    n_fail++;
                    $display("FAIL %s model ch%0d cyc %0d: actual %b expected %b",
                             cur_req, c, cyc, pwm_out[c], model_out(c));
                end
            end
        end
    end

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(logic [1:0] a, logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd_check(string req, logic [1:0] a, logic [31:0] exp);
        @(negedge clk);
        bus_addr = a;
        #1;
        check(req, bus_rdata, exp);
    endtask

    task automatic window(int ch, int n, output int highs, output int rises);
        logic prev;
        highs = 0; rises = 0;
        @(negedge clk);
        prev = pwm_out[ch];
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (pwm_out[ch]) highs++;
            if (pwm_out[ch] && !prev) rises++;
            prev = pwm_out[ch];
        end
    endtask

    initial begin
        int h, r;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        cmp_on = 1;

        // R1 reset state
        cur_req = "R1";
        rd_check("R1 ctrl", 2'd2, 32'h0);
        rd_check("R1 cntA", 2'd0, 32'h0);
        rd_check("R1 cntB", 2'd1, 32'h0);
        check("R1 outputs", {30'h0, pwm_out}, 32'h0);

        // R2 readback
        cur_req = "R2";
        wr(2'd0, 32'h1234_5678);
        wr(2'd1, 32'hdead_beef);
        wr(2'd3, 32'hffff_ffff);
        wr(2'd2, 32'h3c00_0000);
        rd_check("R2 cntA", 2'd0, 32'h1234_5678);
        rd_check("R2 cntB", 2'd1, 32'hdead_beef);
        rd_check("R2 ctrl", 2'd2, 32'h3c00_0000);
        rd_check("R2 addr3", 2'd3, 32'h0);
        wr(2'd2, 32'h0);

        // R3 basic alternation, high 3 low 2 on the always-on strobe
        cur_req = "R3";
        wr(2'd0, 32'h0003_0002);
        wr(2'd2, 32'h0000_0001);
        check("R3 first cycle low", {31'h0, pwm_out[0]}, 32'h0);
        @(negedge clk);
        check("R3 high phase start", {31'h0, pwm_out[0]}, 32'h1);
        window(0, 50, h, r);
        check("R3 high cycles in 50", h, 30);
        check("R3 rises in 50", r, 10);

        // R4 source 1 (every 2nd cycle), divider 1: tick every 4 cycles
        cur_req = "R4";
        wr(2'd0, 32'h0001_0003);
        wr(2'd2, 32'h0000_0111);
        repeat (20) @(negedge clk);
        window(0, 160, h, r);
        check("R4 rises in 160", r, 10);
        check("R4 highs in 160", h, 40);
        wr(2'd2, 32'h0000_0231);   // random source, divider 2
        repeat (200) @(negedge clk);

        // R5 count change during a running high phase
        cur_req = "R5";
        wr(2'd0, 32'h0006_0005);
        wr(2'd2, 32'h0000_0001);
        repeat (3) @(negedge clk);
        wr(2'd0, 32'h0001_0002);
        window(0, 11, h, r);
        check("R5 old phases finish", h, 4);
        repeat (30) @(negedge clk);

        // R6 zero counts
        cur_req = "R6";
        wr(2'd0, 32'h0000_0000);
        repeat (5) @(negedge clk);
        window(0, 40, h, r);
        check("R6 both zero stays low", h, 0);
        wr(2'd0, 32'h0002_0000);
        repeat (5) @(negedge clk);
        window(0, 40, h, r);
        check("R6 zero low count skipped", h, 40);
        wr(2'd0, 32'h0000_0003);
        repeat (5) @(negedge clk);
        window(0, 40, h, r);
        check("R6 zero high count skipped", h, 0);

        // R7 constant mode
        cur_req = "R7";
        wr(2'd0, 32'h0005_0000);
        wr(2'd2, 32'h1000_0001);
        repeat (2) @(negedge clk);
        window(0, 40, h, r);
        check("R7 constant high", h, 40);
        wr(2'd0, 32'h0003_0003);
        repeat (2) @(negedge clk);
        window(0, 40, h, r);
        check("R7 constant both nonzero low", h, 0);
        check("R7 constant no edges", r, 0);

        // R8 invert, disabled and enabled
        cur_req = "R8";
        wr(2'd2, 32'h0400_0000);
        check("R8 disabled A inverted high", {31'h0, pwm_out[0]}, 32'h1);
        wr(2'd2, 32'h0800_0000);
        check("R8 disabled B inverted high", {30'h0, pwm_out}, 32'h2);
        wr(2'd2, 32'h0000_0000);
        check("R8 disabled plain low", {30'h0, pwm_out}, 32'h0);
        wr(2'd0, 32'h0003_0002);
        wr(2'd2, 32'h0400_0001);
        repeat (5) @(negedge clk);
        window(0, 50, h, r);
        check("R8 inverted highs", h, 20);
        wr(2'd2, 32'h1400_0001);
        wr(2'd0, 32'h0000_0004);
        repeat (2) @(negedge clk);
        window(0, 20, h, r);
        check("R8 inverted constant low becomes high", h, 20);

        // R9 both channels, different sources and dividers
        cur_req = "R9";
        wr(2'd0, 32'h0007_0001);
        wr(2'd1, 32'h0002_0005);
        wr(2'd2, 32'h0002_0033);
        repeat (300) @(negedge clk);
        wr(2'd2, 32'h0800_0063);
        repeat (300) @(negedge clk);
        wr(2'd2, 32'h0000_0001);
        window(1, 20, h, r);
        check("R9 B disabled while A runs", h, 0);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule